// File: doc/BRIEF.md
# CSR Access Execute Unit

This unit carries out the six control-register access operations of a 32-bit RISC-V style core. There are three operations: swap, bit-set and bit-clear. Each comes in a form that takes its operand from a register and a form that takes a 5-bit immediate. The core presents the instruction word, the value read from the source register and a one-cycle request strobe. In that same cycle the unit decodes the word and reads the addressed entry of its internal control-register bank. It hands the old value back for the destination register and commits the new value on the clock edge that ends the request cycle.

Read and write strobes are gated by the register indices in the instruction. This means a register is only read, or only written, when the operation actually calls for it. Any side effect tied to a strobe therefore happens exactly when the instruction asks for it and never through a blanket read-modify-write. The unit also recognises the environment-call and breakpoint words and flags malformed or out-of-range encodings as illegal.

Top module: `csrx_unit`

## Requirements
- R1: Outputs respond only in a cycle where `req_i` is high and bits 6:0 of the word equal 1110011. In any other cycle every strobe, flag and `rd_we_o` is low and the bank keeps its contents.
- R2: funct3 (bits 14:12) 001 is a swap: the register at address bits 31:20 takes the rs1 value. `rd_data_o` carries the value held before the update. `rd_we_o` is high only when rd (bits 11:7) is nonzero.
- R3: For both swap forms (funct3 001 and 101) with rd equal to zero, `csr_rd_o` stays low and `rd_data_o` is zero, while `csr_wr_o` still fires.
- R4: funct3 010 sets, and 011 clears, every register bit where the operand has a 1. Bits where the operand has a 0 are left unchanged.
- R5: For set and clear forms (funct3 010, 011, 110, 111) whose source field (bits 19:15) is zero, `csr_wr_o` stays low. A nonzero source index whose register value is zero still fires `csr_wr_o`, with the unchanged value.
- R6: funct3 101, 110 and 111 repeat the swap, set and clear operations, using the source field zero-extended to 32 bits in place of the rs1 value.
- R7: Word 0x00000073 raises `ecall_o` and word 0x00100073 raises `ebreak_o`. At most one of `ecall_o`, `ebreak_o` and `illegal_o` is high at a time.
- R8: `illegal_o` rises for funct3 000 on any other word, for funct3 100, and for an access to an address outside the bank (base 0x000, four entries by default). In those cases no strobe and no `rd_we_o` is issued.
- R9: Reset clears every bank entry to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, one cycle per instruction |
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | XLEN | Value of the source register |
| csr_addr_o | output | 12 | Addressed control register |
| csr_rd_o | output | 1 | Read strobe |
| csr_wr_o | output | 1 | Write strobe |
| csr_wdata_o | output | XLEN | Value written on the ending edge |
| rd_data_o | output | XLEN | Old register value for rd |
| rd_we_o | output | 1 | Register-file write enable |
| ecall_o | output | 1 | Environment-call flag |
| ebreak_o | output | 1 | Breakpoint flag |
| illegal_o | output | 1 | Illegal-encoding flag |

## Verification
The bench builds the unit with its defaults: a 32-bit datapath and four bank entries at base 0x000. This keeps the addressed range small enough to sweep every funct3 value and both rd classes (zero and nonzero). The sweep also covers a zero, small and all-ones source field, four in-range addresses plus the first out-of-range one, and both the system opcode and a foreign one. Every fourth operand value is zero, so the nonzero-index, zero-value write case of R5 appears throughout. A bench-side model of the four registers carries state across the whole sweep, so any wrong commit shows up on a later read.

// File: rtl/csrx_pkg.sv
package csrx_pkg;

   localparam logic [6:0] SYS_OPCODE = 7'b1110011;
   localparam int         ADDR_W     = 12;
   localparam int         IDX_W      = 5;

   // Low two funct3 bits select the operation; bit 2 selects the immediate form.
   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_SWAP  = 2'b01,
      OP_SET   = 2'b10,
      OP_CLEAR = 2'b11
   } csr_op_e;

   typedef struct packed {
      logic              is_sys;
      csr_op_e           op;
      logic              imm_form;
      logic              is_ecall;
      logic              is_ebreak;
      logic              bad_enc;
      logic [ADDR_W-1:0] addr;
      logic [IDX_W-1:0]  src_idx;
      logic [IDX_W-1:0]  rd_idx;
   } csr_dec_t;

endpackage

// File: rtl/csrx_decode.sv
module csrx_decode
   import csrx_pkg::*;
(
   input  logic [31:0] instr_i,
   output csr_dec_t    dec_o
);

   logic [2:0] funct3;
   logic       zero_body;

   assign funct3    = instr_i[14:12];
   // every field except the address low bit and opcode is zero
   assign zero_body = (instr_i[31:21] == 11'd0) && (instr_i[19:7] == 13'd0);

   always_comb begin
      dec_o           = '0;
      dec_o.is_sys    = (instr_i[6:0] == SYS_OPCODE);
      dec_o.addr      = instr_i[31:20];
      dec_o.src_idx   = instr_i[19:15];
      dec_o.rd_idx    = instr_i[11:7];
      dec_o.imm_form  = funct3[2];
      dec_o.op        = csr_op_e'(funct3[1:0]);
      if (dec_o.is_sys && funct3 == 3'b000) begin
         dec_o.is_ecall  = zero_body && !instr_i[20];
         dec_o.is_ebreak = zero_body &&  instr_i[20];
         dec_o.bad_enc   = !zero_body;
      end else if (dec_o.is_sys && funct3 == 3'b100) begin
         dec_o.bad_enc   = 1'b1;
         dec_o.op        = OP_NONE;
      end
   end

endmodule

// File: rtl/csrx_update.sv
module csrx_update
   import csrx_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  csr_op_e           op_i,
   input  logic              imm_form_i,
   input  logic [IDX_W-1:0]  src_idx_i,
   input  logic [XLEN-1:0]   rs1_val_i,
   input  logic [XLEN-1:0]   old_i,
   output logic [XLEN-1:0]   new_o
);

   logic [XLEN-1:0] operand;

   generate
      if (XLEN > IDX_W) begin : g_zext
         assign operand = imm_form_i ? {{(XLEN-IDX_W){1'b0}}, src_idx_i} : rs1_val_i;
      end else begin : g_trunc
         assign operand = imm_form_i ? src_idx_i[XLEN-1:0] : rs1_val_i;
      end
   endgenerate

   always_comb begin
      unique case (op_i)
         OP_SWAP:  new_o = operand;
         OP_SET:   new_o = old_i | operand;
         OP_CLEAR: new_o = old_i & ~operand;
         default:  new_o = old_i;
      endcase
   end

endmodule

// File: rtl/csrx_bank.sv
module csrx_bank
   import csrx_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int NUM_CSR  = 4,
   parameter int CSR_BASE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic [XLEN-1:0]   wdata_i,
   output logic [XLEN-1:0]   rdata_o,
   output logic              hit_o
);

   logic [NUM_CSR-1:0][XLEN-1:0] regs;
   logic [NUM_CSR-1:0]           sel;

   generate
      for (genvar i = 0; i < NUM_CSR; i++) begin : g_entry
         localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CSR_BASE + i);
         assign sel[i] = (addr_i == MY_ADDR);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              regs[i] <= '0;
            else if (wr_i && sel[i]) regs[i] <= wdata_i;
         end
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      for (int j = 0; j < NUM_CSR; j++)
         if (sel[j]) rdata_o = regs[j];
   end

   assign hit_o = |sel;

   AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(regs)) else $error("bank changed without write"); // R1

   AST_BANK_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && hit_o) |=> (rdata_o == $past(wdata_i)) || (addr_i != $past(addr_i)))
      else $error("write not committed"); // R2

endmodule

// File: rtl/csrx_unit.sv
module csrx_unit
   import csrx_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int NUM_CSR  = 4,
   parameter int CSR_BASE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [31:0]       instr_i,
   input  logic [XLEN-1:0]   rs1_val_i,
   output logic [11:0]       csr_addr_o,
   output logic              csr_rd_o,
   output logic              csr_wr_o,
   output logic [XLEN-1:0]   csr_wdata_o,
   output logic [XLEN-1:0]   rd_data_o,
   output logic              rd_we_o,
   output logic              ecall_o,
   output logic              ebreak_o,
   output logic              illegal_o
);

   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (NUM_CSR < 1) begin : g_chk_num
         $error("NUM_CSR must be at least 1");
      end
      if (CSR_BASE < 0 || CSR_BASE + NUM_CSR > ADDR_SPAN) begin : g_chk_range
         $error("bank exceeds the 12-bit address space");
      end
      if (XLEN < 1) begin : g_chk_xlen
         $error("XLEN must be positive");
      end
   endgenerate

   csr_dec_t        dec;
   logic [XLEN-1:0] old_val;
   logic [XLEN-1:0] new_val;
   logic            hit;
   logic            act;
   logic            is_access;
   logic            read_en;
   logic            write_en;

   csrx_decode i_decode (
      .instr_i (instr_i),
      .dec_o   (dec)
   );

   csrx_update #(.XLEN(XLEN)) i_update (
      .op_i       (dec.op),
      .imm_form_i (dec.imm_form),
      .src_idx_i  (dec.src_idx),
      .rs1_val_i  (rs1_val_i),
      .old_i      (old_val),
      .new_o      (new_val)
   );

   csrx_bank #(.XLEN(XLEN), .NUM_CSR(NUM_CSR), .CSR_BASE(CSR_BASE)) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_i  (dec.addr),
      .wr_i    (csr_wr_o),
      .wdata_i (new_val),
      .rdata_o (old_val),
      .hit_o   (hit)
   );

   assign act       = req_i && dec.is_sys;
   assign is_access = act && (dec.op != OP_NONE) && !dec.bad_enc;
   // swap skips the read for rd = 0; set/clear skip the write for a zero source field
   assign read_en   = (dec.op != OP_SWAP) || (dec.rd_idx != '0);
   assign write_en  = (dec.op == OP_SWAP) || (dec.src_idx != '0);

   assign csr_addr_o  = dec.addr;
   assign csr_rd_o    = is_access && hit && read_en;
   assign csr_wr_o    = is_access && hit && write_en;
   assign csr_wdata_o = new_val;
   assign rd_data_o   = csr_rd_o ? old_val : '0;
   assign rd_we_o     = csr_rd_o && (dec.rd_idx != '0);
   assign ecall_o     = act && dec.is_ecall;
   assign ebreak_o    = act && dec.is_ebreak;
   assign illegal_o   = act && (dec.bad_enc || ((dec.op != OP_NONE) && !hit));

   AST_SWAP_RD0_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && instr_i[6:0] == SYS_OPCODE && instr_i[13:12] == 2'b01 && instr_i[11:7] == 5'd0)
      |-> !csr_rd_o) else $error("read strobe on rd=0 swap"); // R3

   AST_SETCLR_ZERO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && instr_i[6:0] == SYS_OPCODE && instr_i[13] && instr_i[19:15] == 5'd0)
      |-> !csr_wr_o) else $error("write strobe with zero source"); // R5

   AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> !(csr_rd_o || csr_wr_o || rd_we_o)) else $error("strobe on illegal"); // R8

   AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ecall_o, ebreak_o, illegal_o})) else $error("several flags"); // R7

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |-> !(csr_rd_o || csr_wr_o || rd_we_o || ecall_o || ebreak_o || illegal_o))
      else $error("activity without request"); // R1

   AST_RDWE_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_we_o |-> (csr_rd_o && instr_i[11:7] != 5'd0)) else $error("bad rd_we"); // R2

endmodule

// File: tb/test_csrx_unit.sv
module test_csrx_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic [31:0] instr_i = '0;
   logic [31:0] rs1_val_i = '0;
   logic [11:0] csr_addr_o;
   logic        csr_rd_o, csr_wr_o, rd_we_o, ecall_o, ebreak_o, illegal_o;
   logic [31:0] csr_wdata_o, rd_data_o;

   int errs = 0;
   int checks = 0;
   bit finished = 0;
   logic [31:0] mdl [4];

   always #10 clk = ~clk;

   csrx_unit i_csrx_unit (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .instr_i(instr_i), .rs1_val_i(rs1_val_i),
      .csr_addr_o(csr_addr_o), .csr_rd_o(csr_rd_o), .csr_wr_o(csr_wr_o),
      .csr_wdata_o(csr_wdata_o), .rd_data_o(rd_data_o), .rd_we_o(rd_we_o),
      .ecall_o(ecall_o), .ebreak_o(ebreak_o), .illegal_o(illegal_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s instr=%h actual=%h expected=%h", tag, instr_i, act, exp);
      end
   endtask

   task automatic run_op(input logic [31:0] ins, input logic [31:0] v, input bit rq);
      logic [6:0]  opc  = ins[6:0];
      logic [2:0]  f3   = ins[14:12];
      logic [4:0]  rd   = ins[11:7];
      logic [4:0]  src  = ins[19:15];
      logic [11:0] addr = ins[31:20];
      bit e_rd = 0, e_wr = 0, e_ec = 0, e_eb = 0, e_il = 0, e_we = 0;
      logic [31:0] e_data = '0, e_new = '0, opnd;
      string tag = "R1";
      if (rq && opc == 7'b1110011) begin
         if (f3 == 3'd0) begin
            tag  = "R7";
            e_ec = (ins == 32'h0000_0073);
            e_eb = (ins == 32'h0010_0073);
            e_il = !e_ec && !e_eb;
            if (e_il) tag = "R8";
         end else if (f3 == 3'd4 || addr > 12'd3) begin
            tag  = "R8";
            e_il = 1;
         end else begin
            opnd = f3[2] ? {27'd0, src} : v;
            e_rd = (f3[1:0] != 2'b01) || (rd != 0);
            e_wr = (f3[1:0] == 2'b01) || (src != 0);
            e_we = e_rd && (rd != 0);
            e_data = e_rd ? mdl[addr[1:0]] : 32'd0;
            case (f3[1:0])
               2'b01:   e_new = opnd;
               2'b10:   e_new = mdl[addr[1:0]] | opnd;
               default: e_new = mdl[addr[1:0]] & ~opnd;
            endcase
            if (f3[1:0] == 2'b01) tag = (rd == 0) ? "R3" : "R2";
            else if (src == 0) tag = "R5";
            else if (!f3[2] && v == 0) tag = "R5";
            else tag = "R4";
            if (f3[2] && src != 0) tag = (f3[1:0] == 2'b01 && rd == 0) ? "R3" : "R6";
         end
      end
      @(negedge clk);
      instr_i = ins; rs1_val_i = v; req_i = rq;
      #5;
      chk(tag, {26'd0, csr_rd_o, csr_wr_o, ecall_o, ebreak_o, illegal_o, rd_we_o},
          {26'd0, e_rd, e_wr, e_ec, e_eb, e_il, e_we});
      chk(tag, rd_data_o, e_data);
      if (e_wr) begin
         chk(tag, csr_wdata_o, e_new);
         chk(tag, {20'd0, csr_addr_o}, {20'd0, addr});
         mdl[addr[1:0]] = e_new;
      end
   endtask

   task automatic readback(input string tag);
      for (int a = 0; a < 4; a++) begin
         // set form with zero source and rd=x1: pure read
         run_op({a[11:0], 5'd0, 3'b010, 5'd1, 7'b1110011}, 32'hFFFF_FFFF, 1'b1);
         chk(tag, rd_data_o, mdl[a]);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errs++; checks++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      int k = 0;
      logic [4:0] srcs [3] = '{5'd0, 5'd7, 5'd31};
      for (int a = 0; a < 4; a++) mdl[a] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      readback("R9");
      // request low: a swap of all-ones must not land (R1)
      run_op({12'h002, 5'd3, 3'b001, 5'd1, 7'b1110011}, 32'hFFFF_FFFF, 1'b0);
      readback("R1");
      // R7 exact words and near misses
      run_op(32'h0000_0073, 32'h1, 1'b1);
      run_op(32'h0010_0073, 32'h1, 1'b1);
      run_op(32'h0020_0073, 32'h1, 1'b1);
      run_op(32'h0000_00F3, 32'h1, 1'b1);
      run_op(32'h0000_8073, 32'h1, 1'b1);
      // sweep
      for (int o = 0; o < 2; o++)
         for (int f = 0; f < 8; f++)
            for (int r = 0; r < 2; r++)
               for (int s = 0; s < 3; s++)
                  for (int a = 0; a < 5; a++) begin
                     logic [31:0] v = (k % 4 == 0) ? 32'd0 : k * 32'h9E37_79B9;
                     logic [6:0]  opc = (o == 0) ? 7'b1110011 : 7'b0110011;
                     run_op({a[11:0], srcs[s], f[2:0], (r == 0) ? 5'd0 : 5'd3, opc}, v, 1'b1);
                     k++;
                  end
      readback("R4");
      // R5 explicit: nonzero index holding zero rewrites the same value
      run_op({12'h002, 5'd9, 3'b011, 5'd0, 7'b1110011}, 32'd0, 1'b1);
      chk("R5", {31'd0, csr_wr_o}, 32'd1);
      readback("R5");
      // reset mid-run clears the bank
      @(negedge clk);
      req_i = 1'b0;
      rst_n = 1'b0;
      for (int a = 0; a < 4; a++) mdl[a] = '0;
      @(negedge clk);
      rst_n = 1'b1;
      readback("R9");
      @(negedge clk);
      req_i = 1'b0;
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule